// File: doc/BRIEF.md
# Microcycle occupation bitmap tracker

A router that shares one wire among several nets in a clock cycle needs to know, for every wire, how many nets use it in each microcycle. This block does that bookkeeping in hardware. A command gives a wire index, the time a signal reaches the wire and the wire's own delay. The block derives the leave time and turns the time window into an occupation bitmap with one bit per microcycle. A guard band widens the window on both sides, so that skew in the microcycle clock cannot hide an overlap. The bitmap is then added to that wire's row of per-microcycle occupancy counters, or removed from it.

The microcycle length and the guard band sit in two configuration registers, written before use. A clear command zeroes every counter. A scan command walks all wires, one per cycle, and reports whether every wire is used by at most one net in every microcycle. That is the condition for a legal routing, since a wire node has a capacity of one.

Control is one state machine with five states. ST_IDLE accepts a command. An add or a rip-up goes to ST_UPDATE, clear goes to ST_CLEAR and scan goes to ST_SCAN. ST_UPDATE and ST_CLEAR return to ST_IDLE after one cycle. ST_SCAN stays for one cycle per wire and then moves to ST_DONE. ST_DONE returns to ST_IDLE after one cycle.

Top module: `mc_occ_tracker`

## Requirements
- R1: After reset, every counter is zero, `busy`, `done` and `err_sticky` are 0, `legal` is 1, and `bitmap` and `occ_row` are 0.
- R2: Take microcycle index i running from 1 to MC, stored in `bitmap` bit i-1, so bit 0 is the first microcycle. The bit is 0 when the arrival time exceeds i·Tu + Tgb. Otherwise it is 0 when the leave time is below (i-1)·Tu − Tgb. Otherwise it is 1. `bitmap` shows the bitmap of the last add or rip-up.
- R3: The leave time is `cmd_arrival + cmd_delay`, computed without wrap-around.
- R4: `cmd_op` 0 (add) increments the counter of every microcycle whose bitmap bit is 1 in row `cmd_wire`. One clock edge after the accepting edge, `occ_row` shows that row. Lane j occupies bits [j·CW +: CW], and lane 0 is the first microcycle. `occ_row` changes at no other time.
- R5: `cmd_op` 1 (rip-up) decrements the counter of every microcycle whose bitmap bit is 1, with the same timing and row display as R4.
- R6: If a rip-up would take any selected counter below zero, the whole command is ignored and `err_sticky` is set. `occ_row` then shows the unchanged row. `err_sticky` stays set until reset.
- R7: If an add would take any selected counter past 2^CW − 1, the whole command is ignored and `err_sticky` is set. `occ_row` then shows the unchanged row.
- R8: `cmd_op` 2 (clear) zeroes every counter of every wire in one busy cycle. `err_sticky` is not affected.
- R9: `cmd_op` 3 (scan) holds `busy` for WIRES + 1 cycles. `done` is high for exactly the last of them. From that cycle on, `legal` is 1 exactly when no counter of any wire exceeds 1.
- R10: When `cfg_we` is high at a clock edge, `cfg_data` is loaded into Tu if `cfg_sel` is 0, or into Tgb if `cfg_sel` is 1. Both reset to 0.
- R11: A command is accepted only at an edge where `cmd_valid` is high and `busy` is low. `cmd_valid` while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects microcycle length, 1 selects guard band |
| cfg_data | input | TW | Configuration value |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 0 add, 1 rip-up, 2 clear, 3 scan |
| cmd_wire | input | log2(WIRES) | Wire index |
| cmd_arrival | input | TW | Arrival time, unsigned fixed point |
| cmd_delay | input | TW | Wire delay, unsigned fixed point |
| busy | output | 1 | High while a command is in progress |
| done | output | 1 | One-cycle pulse at the end of a scan |
| legal | output | 1 | Result of the last scan |
| err_sticky | output | 1 | A rip-up underflow or add overflow was refused |
| bitmap | output | MC | Occupation bitmap of the last add or rip-up |
| occ_row | output | MC·CW | Counter row of the wire after the last add or rip-up |

## Verification
The bench builds the block with MC = 8, WIRES = 8, CW = 2 and TW = 16. The 2-bit counters put the refused-overflow case within reach after only three adds. The short wire array keeps each scan to nine busy cycles, so many scans fit between random adds and rip-ups. With eight microcycles and a configurable guard band, windows that straddle microcycle borders are exercised. So are windows whose guard band pulls in an extra microcycle on either side, and windows that start before time zero.

// File: rtl/mc_occ_pkg.sv
package mc_occ_pkg;

    typedef enum logic [1:0] {
        OP_ADD   = 2'd0,
        OP_RIP   = 2'd1,
        OP_CLEAR = 2'd2,
        OP_SCAN  = 2'd3
    } occ_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UPDATE,
        ST_CLEAR,
        ST_SCAN,
        ST_DONE
    } occ_state_e;

endpackage

// File: rtl/mc_occ_bitmap.sv
module mc_occ_bitmap #(
    parameter int MC = 8,
    parameter int TW = 16
) (
    input  logic [TW-1:0] arr,
    input  logic [TW:0]   leave,
    input  logic [TW-1:0] tu,
    input  logic [TW-1:0] tgb,
    output logic [MC-1:0] bm
);
    // wide enough for MC*tu + tgb without wrap
    localparam int XW = TW + $clog2(MC + 1) + 1;

    logic [XW-1:0] arr_x;
    logic [XW-1:0] lvg_x;

    assign arr_x = XW'(arr);
    // leave + tgb compared against (i-1)*tu avoids a negative lower bound
    assign lvg_x = XW'(leave) + XW'(tgb);

    for (genvar g = 0; g < MC; g++) begin : g_bit
        logic [XW-1:0] hi_lim;
        logic [XW-1:0] lo_lim;
        assign hi_lim = XW'(g + 1) * XW'(tu) + XW'(tgb);
        assign lo_lim = XW'(g) * XW'(tu);
        assign bm[g]  = (arr_x <= hi_lim) && (lvg_x >= lo_lim);
    end

endmodule

// File: rtl/mc_occ_rowupd.sv
module mc_occ_rowupd #(
    parameter int MC = 8,
    parameter int CW = 4
) (
    input  logic [MC*CW-1:0] row_in,
    input  logic [MC-1:0]    bm,
    input  logic             rip,
    output logic [MC*CW-1:0] row_out,
    output logic             fault
);
    logic [MC*CW-1:0] row_nx;
    logic [MC-1:0]    lane_fault;

    for (genvar g = 0; g < MC; g++) begin : g_lane
        logic [CW-1:0] lane;
        logic [CW-1:0] lane_nx;
        assign lane           = row_in[g*CW +: CW];
        assign lane_nx        = rip ? (lane - CW'(1)) : (lane + CW'(1));
        assign lane_fault[g]  = bm[g] & (rip ? (lane == '0) : (&lane));
        assign row_nx[g*CW +: CW] = bm[g] ? lane_nx : lane;
    end

    assign fault   = |lane_fault;
    assign row_out = fault ? row_in : row_nx;

endmodule

// File: rtl/mc_occ_store.sv
module mc_occ_store #(
    parameter int WIRES = 16,
    parameter int MC    = 8,
    parameter int CW    = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     wr_en,
    input  logic [$clog2(WIRES)-1:0] wr_addr,
    input  logic [MC*CW-1:0]         wr_row,
    input  logic [$clog2(WIRES)-1:0] rd_addr,
    output logic [MC*CW-1:0]         rd_row
);
    localparam int ROWW = MC * CW;

    logic [ROWW-1:0] mem [WIRES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < WIRES; w++) mem[w] <= '0;
        end else if (clr) begin
            for (int w = 0; w < WIRES; w++) mem[w] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_row;
        end
    end

    assign rd_row = mem[rd_addr];

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (rd_row == '0)); // R8

endmodule

// File: rtl/mc_occ_tracker.sv
module mc_occ_tracker #(
    parameter int MC    = 8,
    parameter int WIRES = 16,
    parameter int CW    = 4,
    parameter int TW    = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic                     cfg_sel,
    input  logic [TW-1:0]            cfg_data,
    input  logic                     cmd_valid,
    input  logic [1:0]               cmd_op,
    input  logic [$clog2(WIRES)-1:0] cmd_wire,
    input  logic [TW-1:0]            cmd_arrival,
    input  logic [TW-1:0]            cmd_delay,
    output logic                     busy,
    output logic                     done,
    output logic                     legal,
    output logic                     err_sticky,
    output logic [MC-1:0]            bitmap,
    output logic [MC*CW-1:0]         occ_row
);
    import mc_occ_pkg::*;

    localparam int AW   = $clog2(WIRES);
    localparam int ROWW = MC * CW;

    occ_state_e      state_q, state_d;
    occ_op_e         op_q;
    logic [AW-1:0]   wire_q;
    logic [TW-1:0]   arr_q;
    logic [TW:0]     leave_q;
    logic [TW-1:0]   tu_q;
    logic [TW-1:0]   tgb_q;
    logic [AW-1:0]   scan_idx_q;
    logic            fail_acc_q;
    logic            legal_q;
    logic            err_q;
    logic [ROWW-1:0] row_q;
    logic [MC-1:0]   bm_q;

    logic            accept;
    logic            scan_last;
    logic [AW-1:0]   rd_addr;
    logic [ROWW-1:0] rd_row;
    logic [ROWW-1:0] upd_row;
    logic            upd_fault;
    logic [MC-1:0]   bm_w;
    logic [MC-1:0]   lane_over;
    logic            row_over;
    logic            store_clr;
    logic            store_we;

    assign accept    = cmd_valid && (state_q == ST_IDLE);
    assign scan_last = (scan_idx_q == AW'(WIRES - 1));
    assign rd_addr   = (state_q == ST_SCAN) ? scan_idx_q : wire_q;

    mc_occ_bitmap #(.MC(MC), .TW(TW)) u_bitmap (
        .arr   (arr_q),
        .leave (leave_q),
        .tu    (tu_q),
        .tgb   (tgb_q),
        .bm    (bm_w)
    );

    mc_occ_rowupd #(.MC(MC), .CW(CW)) u_rowupd (
        .row_in  (rd_row),
        .bm      (bm_w),
        .rip     (op_q == OP_RIP),
        .row_out (upd_row),
        .fault   (upd_fault)
    );

    mc_occ_store #(.WIRES(WIRES), .MC(MC), .CW(CW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (store_clr),
        .wr_en   (store_we),
        .wr_addr (wire_q),
        .wr_row  (upd_row),
        .rd_addr (rd_addr),
        .rd_row  (rd_row)
    );

    // a lane is over capacity when it holds 2 or more
    for (genvar g = 0; g < MC; g++) begin : g_over
        assign lane_over[g] = |rd_row[g*CW+1 +: CW-1];
    end
    assign row_over = |lane_over;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    unique case (occ_op_e'(cmd_op))
                        OP_ADD, OP_RIP: state_d = ST_UPDATE;
                        OP_CLEAR:       state_d = ST_CLEAR;
                        OP_SCAN:        state_d = ST_SCAN;
                        default:        state_d = ST_IDLE;
                    endcase
                end
            end
            ST_UPDATE: state_d = ST_IDLE;
            ST_CLEAR:  state_d = ST_IDLE;
            ST_SCAN:   if (scan_last) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs decoded from state
    always_comb begin
        busy      = 1'b1;
        done      = 1'b0;
        store_clr = 1'b0;
        store_we  = 1'b0;
        unique case (state_q)
            ST_IDLE:   busy = 1'b0;
            ST_UPDATE: store_we = !upd_fault;
            ST_CLEAR:  store_clr = 1'b1;
            ST_SCAN:   ;
            ST_DONE:   done = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

    // command latch, configuration, results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q       <= OP_ADD;
            wire_q     <= '0;
            arr_q      <= '0;
            leave_q    <= '0;
            tu_q       <= '0;
            tgb_q      <= '0;
            scan_idx_q <= '0;
            fail_acc_q <= 1'b0;
            legal_q    <= 1'b1;
            err_q      <= 1'b0;
            row_q      <= '0;
            bm_q       <= '0;
        end else begin
            if (cfg_we) begin
                if (cfg_sel) tgb_q <= cfg_data;
                else         tu_q  <= cfg_data;
            end
            if (accept) begin
                op_q       <= occ_op_e'(cmd_op);
                wire_q     <= cmd_wire;
                arr_q      <= cmd_arrival;
                leave_q    <= {1'b0, cmd_arrival} + {1'b0, cmd_delay};
                scan_idx_q <= '0;
                fail_acc_q <= 1'b0;
            end
            if (state_q == ST_UPDATE) begin
                row_q <= upd_row;
                bm_q  <= bm_w;
                if (upd_fault) err_q <= 1'b1;
            end
            if (state_q == ST_SCAN) begin
                scan_idx_q <= scan_idx_q + AW'(1);
                fail_acc_q <= fail_acc_q | row_over;
                if (scan_last) legal_q <= !(fail_acc_q | row_over);
            end
        end
    end

    assign legal      = legal_q;
    assign err_sticky = err_q;
    assign bitmap     = bm_q;
    assign occ_row    = row_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky); // R6
    AST_FAULT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UPDATE && upd_fault) |=> err_sticky); // R7
    AST_BITMAP_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UPDATE) |-> ($countones(bm_w & ~(bm_w << 1)) <= 1)); // R2
    AST_ROW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_UPDATE) |=> $stable(occ_row)); // R4
    AST_SCAN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN) |=> busy); // R11

endmodule

// File: tb/mc_occ_tracker_test.sv
module mc_occ_tracker_test;

    localparam int MC = 8;
    localparam int WIRES = 8;
    localparam int CW = 2;
    localparam int TW = 16;
    localparam int CMAX = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic cfg_sel = 1'b0;
    logic [TW-1:0] cfg_data = '0;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_op = '0;
    logic [2:0] cmd_wire = '0;
    logic [TW-1:0] cmd_arrival = '0;
    logic [TW-1:0] cmd_delay = '0;
    logic busy, done, legal, err_sticky;
    logic [MC-1:0] bitmap;
    logic [MC*CW-1:0] occ_row;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    mc_occ_tracker #(.MC(MC), .WIRES(WIRES), .CW(CW), .TW(TW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_wire(cmd_wire), .cmd_arrival(cmd_arrival), .cmd_delay(cmd_delay),
        .busy(busy), .done(done), .legal(legal), .err_sticky(err_sticky),
        .bitmap(bitmap), .occ_row(occ_row)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_cnt [WIRES][MC];
    int m_ph;            // 0 idle, 1 update, 2 clear, 3 scan, 4 done
    int m_left;
    int m_op, m_wire, m_arr, m_dly;
    int m_tu, m_tgb;
    bit m_legal, m_err;
    logic [MC-1:0] m_bm;
    logic [MC*CW-1:0] m_row;

    function automatic logic [MC-1:0] ref_bitmap(int arr, int lv, int tu, int tgb);
        logic [MC-1:0] b;
        for (int i = 1; i <= MC; i++) begin
            if (arr > i * tu + tgb)             b[i-1] = 1'b0;
            else if (lv < (i - 1) * tu - tgb)   b[i-1] = 1'b0;
            else                                b[i-1] = 1'b1;
        end
        return b;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WIRES; w++)
                for (int j = 0; j < MC; j++) m_cnt[w][j] = 0;
            m_ph = 0; m_left = 0; m_tu = 0; m_tgb = 0;
            m_legal = 1'b1; m_err = 1'b0; m_bm = '0; m_row = '0;
            m_op = 0; m_wire = 0; m_arr = 0; m_dly = 0;
        end else begin
            case (m_ph)
                0: if (cmd_valid) begin
                    m_op = cmd_op; m_wire = cmd_wire;
                    m_arr = cmd_arrival; m_dly = cmd_delay;
                    if (m_op <= 1) m_ph = 1;
                    else if (m_op == 2) m_ph = 2;
                    else begin m_ph = 3; m_left = WIRES; end
                end
                1: begin
                    bit bad;
                    bad = 1'b0;
                    m_bm = ref_bitmap(m_arr, m_arr + m_dly, m_tu, m_tgb);
                    for (int j = 0; j < MC; j++)
                        if (m_bm[j] && ((m_op == 1) ? (m_cnt[m_wire][j] == 0) : (m_cnt[m_wire][j] == CMAX)))
                            bad = 1'b1;
                    if (bad) m_err = 1'b1;
                    else
                        for (int j = 0; j < MC; j++)
                            if (m_bm[j]) m_cnt[m_wire][j] += (m_op == 1) ? -1 : 1;
                    for (int j = 0; j < MC; j++) m_row[j*CW +: CW] = CW'(m_cnt[m_wire][j]);
                    m_ph = 0;
                end
                2: begin
                    for (int w = 0; w < WIRES; w++)
                        for (int j = 0; j < MC; j++) m_cnt[w][j] = 0;
                    m_ph = 0;
                end
                3: begin
                    m_left--;
                    if (m_left == 0) begin
                        m_legal = 1'b1;
                        for (int w = 0; w < WIRES; w++)
                            for (int j = 0; j < MC; j++)
                                if (m_cnt[w][j] > 1) m_legal = 1'b0;
                        m_ph = 4;
                    end
                end
                default: m_ph = 0;
            endcase
            if (cfg_we) begin
                if (cfg_sel) m_tgb = cfg_data;
                else         m_tu = cfg_data;
            end
        end
    end

    // every-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(busy == (m_ph != 0), "R11 busy", busy, m_ph != 0);
            chk(done == (m_ph == 4), "R9 done", done, m_ph == 4);
            chk(legal == m_legal, "R9 legal", legal, m_legal);
            chk(err_sticky == m_err, "R6 err_sticky", err_sticky, m_err);
            chk(bitmap == m_bm, "R2 bitmap", bitmap, m_bm);
            chk(occ_row == m_row, "R4 occ_row", occ_row, m_row);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic cfg_write(input bit sel, input int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_data = TW'(val);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run_cmd(input int op, input int w, input int arr, input int dly);
        @(negedge clk);
        while (busy) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'(op); cmd_wire = 3'(w);
        cmd_arrival = TW'(arr); cmd_delay = TW'(dly);
        @(negedge clk);
        cmd_valid = 1'b0;
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R1 reset state
        chk(busy == 0 && done == 0 && err_sticky == 0, "R1 flags", {busy, done, err_sticky}, 0);
        chk(legal == 1, "R1 legal", legal, 1);
        chk(bitmap == 0 && occ_row == 0, "R1 outputs", {bitmap, occ_row}, 0);

        // R10 configuration, R2/R3 bitmap from arrival + delay
        cfg_write(0, 100);
        cfg_write(1, 10);
        run_cmd(0, 3, 150, 60);
        chk(bitmap == 8'h06, "R3 leave=arr+delay window", bitmap, 8'h06);
        chk(occ_row == 16'h0014, "R4 add row", occ_row, 16'h0014);
        run_cmd(0, 4, 105, 0);
        chk(bitmap == 8'h03, "R10 guard band widens window", bitmap, 8'h03);
        cfg_write(1, 0);
        run_cmd(0, 5, 105, 0);
        chk(bitmap == 8'h02, "R10 zero guard band", bitmap, 8'h02);

        run_cmd(3, 0, 0, 0);
        chk(legal == 1, "R9 scan legal", legal, 1);
        cfg_write(1, 10);
        run_cmd(0, 3, 150, 60);
        chk(occ_row == 16'h0028, "R4 second add", occ_row, 16'h0028);
        run_cmd(3, 0, 0, 0);
        chk(legal == 0, "R9 scan illegal", legal, 0);

        // R11 command while busy is ignored
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd3;
        @(negedge clk);
        cmd_op = 2'd0; cmd_wire = 3'd3; cmd_arrival = 150; cmd_delay = 60;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (busy) @(negedge clk);
        run_cmd(1, 3, 150, 60);
        chk(occ_row == 16'h0014, "R11 busy add ignored", occ_row, 16'h0014);

        // R7 overflow refused
        run_cmd(0, 3, 150, 60);
        run_cmd(0, 3, 150, 60);
        chk(occ_row == 16'h003C && err_sticky == 0, "R7 at max", occ_row, 16'h003C);
        run_cmd(0, 3, 150, 60);
        chk(occ_row == 16'h003C, "R7 overflow ignored", occ_row, 16'h003C);
        chk(err_sticky == 1, "R7 error flag", err_sticky, 1);

        // R8 clear keeps error, zeroes counters
        run_cmd(2, 0, 0, 0);
        chk(err_sticky == 1, "R8 err kept", err_sticky, 1);
        run_cmd(0, 3, 150, 60);
        chk(occ_row == 16'h0014, "R8 counters zeroed", occ_row, 16'h0014);

        // R5/R6 rip-up and underflow on a fresh reset
        do_reset();
        cfg_write(0, 100);
        cfg_write(1, 10);
        run_cmd(0, 2, 150, 60);
        run_cmd(1, 2, 150, 60);
        chk(occ_row == 16'h0000, "R5 rip-up", occ_row, 0);
        chk(err_sticky == 0, "R5 no error", err_sticky, 0);
        run_cmd(1, 2, 150, 60);
        chk(occ_row == 16'h0000, "R6 underflow ignored", occ_row, 0);
        chk(err_sticky == 1, "R6 error flag", err_sticky, 1);

        // mixed traffic against the reference model
        do_reset();
        cfg_write(0, 120);
        cfg_write(1, 8);
        for (int n = 0; n < 400; n++) begin
            int k;
            k = $urandom_range(0, 19);
            if (k == 0) cfg_write(0, $urandom_range(40, 200));
            else if (k == 1) cfg_write(1, $urandom_range(0, 30));
            else if (k == 2) run_cmd(2, 0, 0, 0);
            else if (k < 6) run_cmd(3, 0, 0, 0);
            else if (k < 13) run_cmd(0, $urandom_range(0, WIRES - 1), $urandom_range(0, 1000), $urandom_range(0, 300));
            else run_cmd(1, $urandom_range(0, WIRES - 1), $urandom_range(0, 1000), $urandom_range(0, 300));
        end

        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule